// File: doc/BRIEF.md
# Edge-Triggered Wake-Up Start Logic

This block keeps watch over a bank of 32 general-purpose input pins while the chip sleeps. Each pin has its own chosen edge direction. When that edge appears, a per-pin start event is latched, and it stays latched until software clears it on purpose. A single wake-up interrupt goes high as long as at least one enabled pin holds a latched event. The power-mode controller uses this interrupt to bring the core back up.

Software uses a small word-addressed register bus with four registers. One chooses the edge polarity of each pin. One enables pins onto the interrupt. One is a write-one-to-clear register that removes latched events. The last is a read-only status view. Bits 11:0 serve port 0 pins 0 to 11, bits 23:12 serve port 1 pins 0 to 11, and bits 31:24 serve port 2 pins 0 to 7. Because a latched event can be left over from earlier activity, software is expected to clear the events before it enables any pins.

Top module: `wake_start_unit`

## Requirements
- R1: After reset, the polarity, enable and status registers all read zero and `wakeIrq` is low.
- R2: When a pin's polarity bit (register address 0) is 1, a rising edge on that pin latches an event. When the bit is 0, a falling edge latches it. An edge in the other direction latches nothing.
- R3: Writing a 1 to bit i of the clear register (address 2) removes the latched event of pin i. Writing 0 to bit i leaves that event unchanged.
- R4: Bit i of the status register (address 3) reads 1 only when pin i has a latched event and enable bit i (address 1) is 1. Otherwise it reads 0.
- R5: A pin latches events even while its enable bit is 0. Setting the enable bit later makes the pending event show up in status and raises `wakeIrq`.
- R6: `wakeIrq` is high exactly when the status register would read a nonzero value, and it stays high until the matching events are cleared or disabled.
- R7: If a clear write to a bit and a new qualifying edge on the same pin land in the same cycle, the event remains latched.
- R8: The clear register always reads back zero. Writes to the status register change neither the latched events nor the other registers.
- R9: A pin change applied before clock edge k passes two synchroniser flops. The latched event appears after edge k+2, and not earlier.
- R10: Each status bit depends only on its own pin. An edge on one pin never latches an event on any other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pins | input | 32 | Watched inputs: bits 11:0 port 0, bits 23:12 port 1, bits 31:24 port 2 pins 0 to 7 |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 2 | Register select: 0 polarity, 1 enable, 2 clear, 3 status |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busSel is high and busWrite is low |
| wakeIrq | output | 1 | Combined wake-up interrupt |

## Verification
The main table mixes three kinds of pattern. Some have every bit rising under polarity 1. Some have falling edges under polarity 0 and rising edges under polarity 0. Others split one word into alternating polarities with alternating edge directions. Together these show whether the polarity choice is made per bit rather than for the whole bank. Further patterns with partial enables and single isolated bits at the port boundaries (bits 0, 12, 24, 31) show whether the enable masks only the view and whether one pin can leak into another. Directed cases time a clear write onto the exact cycle an edge is detected, and count edges to pin down the synchroniser latency.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [1:0] {
    ADDR_POL  = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_CLR  = 2'd2,
    ADDR_STAT = 2'd3
  } regAddr_e;

  // strobes handed from the bus decoder to the datapath
  typedef struct packed {
    logic wrPol;
    logic wrEn;
    logic wrClr;
  } ctrlStrobes_t;

endpackage

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [1:0]          busAddr,
  input  logic [NUM_PINS-1:0] polarity,
  input  logic [NUM_PINS-1:0] enable,
  input  logic [NUM_PINS-1:0] statusView,
  output ctrlStrobes_t        strobes,
  output logic [DATA_W-1:0]   busRdata
);

  localparam int PAD_W = DATA_W - NUM_PINS;

  logic          isWrite;
  logic          isRead;
  regAddr_e      addrSel;
  logic [NUM_PINS-1:0] readBits;

  assign addrSel = regAddr_e'(busAddr);
  assign isWrite = busSel & busWrite;
  assign isRead  = busSel & ~busWrite;

  always_comb begin
    strobes       = '0;
    strobes.wrPol = isWrite && (addrSel == ADDR_POL);
    strobes.wrEn  = isWrite && (addrSel == ADDR_EN);
    strobes.wrClr = isWrite && (addrSel == ADDR_CLR);
  end

  always_comb begin
    readBits = '0;
    if (isRead) begin
      unique case (addrSel)
        ADDR_POL:  readBits = polarity;
        ADDR_EN:   readBits = enable;
        ADDR_CLR:  readBits = '0;
        ADDR_STAT: readBits = statusView;
      endcase
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign busRdata = {{PAD_W{1'b0}}, readBits};
    end else begin : g_nopad
      assign busRdata = readBits;
    end
  endgenerate

endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pins,
  input  ctrlStrobes_t        strobes,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] polarity,
  output logic [NUM_PINS-1:0] enable,
  output logic [NUM_PINS-1:0] latched,
  output logic [NUM_PINS-1:0] edgeHit,
  output logic [NUM_PINS-1:0] statusView,
  output logic                irq
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];
  logic [NUM_PINS-1:0] syncedNow;
  logic [NUM_PINS-1:0] syncedPrev;
  logic [NUM_PINS-1:0] clearMask;

  // synchroniser chain, one register per stage
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= '0;
          else       syncChain[s] <= pins;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= '0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  assign syncedNow = syncChain[LAST_STAGE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncedPrev <= '0;
    else       syncedPrev <= syncedNow;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polarity <= '0;
      enable   <= '0;
    end else begin
      if (strobes.wrPol) polarity <= wdata;
      if (strobes.wrEn)  enable   <= wdata;
    end
  end

  assign clearMask = strobes.wrClr ? wdata : '0;

  // per-pin edge qualifier and event latch
  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
      logic riseSeen;
      logic fallSeen;
      assign riseSeen   = syncedNow[i] & ~syncedPrev[i];
      assign fallSeen   = ~syncedNow[i] & syncedPrev[i];
      assign edgeHit[i] = polarity[i] ? riseSeen : fallSeen;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          latched[i] <= 1'b0;
        else if (edgeHit[i]) latched[i] <= 1'b1;
        else if (clearMask[i]) latched[i] <= 1'b0;
      end
    end
  endgenerate

  assign statusView = latched & enable;
  assign irq        = |statusView;

endmodule

// File: rtl/wake_start_unit.sv
module wake_start_unit
  import wake_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       pins,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              wakeIrq
);

  ctrlStrobes_t        strobes;
  logic [NUM_PINS-1:0] polarityReg;
  logic [NUM_PINS-1:0] enableReg;
  logic [NUM_PINS-1:0] latchedState;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] statusView;

  wake_ctrl #(
    .NUM_PINS(NUM_PINS),
    .DATA_W  (DATA_W)
  ) u_ctrl (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .polarity  (polarityReg),
    .enable    (enableReg),
    .statusView(statusView),
    .strobes   (strobes),
    .busRdata  (busRdata)
  );

  wake_datapath #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pins      (pins[NUM_PINS-1:0]),
    .strobes   (strobes),
    .wdata     (busWdata[NUM_PINS-1:0]),
    .polarity  (polarityReg),
    .enable    (enableReg),
    .latched   (latchedState),
    .edgeHit   (edgeHit),
    .statusView(statusView),
    .irq       (wakeIrq)
  );

endmodule

// File: rtl/wake_checks.sv
module wake_checks #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWrite,
  input logic [1:0]          busAddr,
  input logic [31:0]         busWdata,
  input logic [NUM_PINS-1:0] latched,
  input logic [NUM_PINS-1:0] edgeHit,
  input logic [NUM_PINS-1:0] polarity,
  input logic [NUM_PINS-1:0] enable,
  input logic                wakeIrq
);

  // R1: reset holds the interrupt low
  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> !wakeIrq)
    else $error("p_reset_quiet_r1");

  // R2: a latched bit can only appear after a qualifying edge
  p_no_spurious_event_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((latched & ~$past(latched) & ~$past(edgeHit)) == '0))
    else $error("p_no_spurious_event_r2");

  // R3: a clear write drops every addressed bit that saw no edge
  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == 2'd2) |=>
      ((latched & $past(busWdata[NUM_PINS-1:0]) & ~$past(edgeHit)) == '0))
    else $error("p_clear_drops_r3");

  // R5: the interrupt needs at least one enabled pin
  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> (enable != '0))
    else $error("p_irq_needs_enable_r5");

  // R7: a detected edge is latched on the next cycle whatever the bus does
  p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (edgeHit != '0) |=> ((latched & $past(edgeHit)) == $past(edgeHit)))
    else $error("p_edge_wins_r7");

  // R8: writes to the status address leave the configuration untouched
  p_status_write_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == 2'd3) |=> ($stable(polarity) && $stable(enable)))
    else $error("p_status_write_ignored_r8");

endmodule

bind wake_start_unit wake_checks #(.NUM_PINS(NUM_PINS)) u_checks (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .latched (latchedState),
  .edgeHit (edgeHit),
  .polarity(polarityReg),
  .enable  (enableReg),
  .wakeIrq (wakeIrq)
);

// File: tb/sim_wake_start_unit.sv
`timescale 1ns/100ps
module sim_wake_start_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pins = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        wakeIrq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  wake_start_unit u0 (
    .clk(clk), .rstN(rstN), .pins(pins), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .wakeIrq(wakeIrq)
  );

  // polarity, enable, starting pins, final pins, expected status, expected irq
  typedef struct packed {
    logic [31:0] pol;
    logic [31:0] en;
    logic [31:0] pinA;
    logic [31:0] pinB;
    logic [31:0] expStat;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_000F, 32'h0000_000F, 1'b1},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0000_FFFF, 1'b1},
    '{32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b1},
    '{32'hFFFF_FFFF, 32'h00FF_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h00FF_0000, 1'b1},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    '{32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h5555_5555, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 1'b1},
    '{32'h8000_0000, 32'h8000_0001, 32'h0000_0000, 32'h8000_0001, 32'h8000_0000, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    waitCycles(3);
    // R1: reset state
    busRd(2'd0, rd); check("R1 polarity", rd, 32'h0);
    busRd(2'd1, rd); check("R1 enable", rd, 32'h0);
    busRd(2'd3, rd); check("R1 status", rd, 32'h0);
    check("R1 irq", {31'b0, wakeIrq}, 32'h0);
    rstN = 1'b1;
    waitCycles(2);

    // R2 R4 R6 R10: table walk
    for (int v = 0; v < NVEC; v++) begin
      busWr(2'd1, 32'h0);
      busWr(2'd0, VECS[v].pol);
      pins = VECS[v].pinA;
      waitCycles(5);
      busWr(2'd2, 32'hFFFF_FFFF);
      busWr(2'd1, VECS[v].en);
      pins = VECS[v].pinB;
      waitCycles(5);
      busRd(2'd3, rd);
      check($sformatf("R2/R4 vector %0d status", v), rd, VECS[v].expStat);
      check($sformatf("R6 vector %0d irq", v), {31'b0, wakeIrq}, {31'b0, VECS[v].expIrq});
    end

    // R3: partial clear, then zero write has no effect
    busWr(2'd1, 32'h0);
    busWr(2'd0, 32'hFFFF_FFFF);
    pins = '0; waitCycles(5);
    busWr(2'd2, 32'hFFFF_FFFF);
    pins = 32'hFFFF_FFFF; waitCycles(5);
    busWr(2'd1, 32'hFFFF_FFFF);
    busWr(2'd2, 32'h0000_000F);
    busRd(2'd3, rd); check("R3 partial clear", rd, 32'hFFFF_FFF0);
    busWr(2'd2, 32'h0);
    busRd(2'd3, rd); check("R3 zero write keeps events", rd, 32'hFFFF_FFF0);

    // R8: clear reads zero, status ignores writes
    busRd(2'd2, rd); check("R8 clear reads zero", rd, 32'h0);
    busWr(2'd3, 32'h0);
    busRd(2'd3, rd); check("R8 status write ignored", rd, 32'hFFFF_FFF0);
    busRd(2'd0, rd); check("R8 polarity untouched", rd, 32'hFFFF_FFFF);

    // R6: irq stays until cleared
    check("R6 irq held", {31'b0, wakeIrq}, 32'h1);
    busWr(2'd2, 32'hFFFF_FFFF);
    check("R6 irq drops after clear", {31'b0, wakeIrq}, 32'h0);

    // R5: latch while disabled, enable later
    busWr(2'd1, 32'h0);
    pins = '0; waitCycles(5);
    busWr(2'd2, 32'hFFFF_FFFF);
    pins = 32'h0000_1000; waitCycles(5);
    check("R5 irq low while disabled", {31'b0, wakeIrq}, 32'h0);
    busRd(2'd3, rd); check("R5 status hidden while disabled", rd, 32'h0);
    busWr(2'd1, 32'h0000_1000);
    check("R5 irq after enable", {31'b0, wakeIrq}, 32'h1);
    busRd(2'd3, rd); check("R5 R10 status bit 12 only", rd, 32'h0000_1000);

    // R9: latency, bit 24 isolated
    busWr(2'd1, 32'h0100_0000);
    busWr(2'd2, 32'hFFFF_FFFF);
    @(negedge clk); pins = 32'h0100_1000;       // change before edge k
    @(negedge clk);                               // after edge k
    @(negedge clk);                               // after edge k+1
    check("R9 not yet latched", {31'b0, wakeIrq}, 32'h0);
    @(negedge clk);                               // after edge k+2
    check("R9 latched after third edge", {31'b0, wakeIrq}, 32'h1);
    busRd(2'd3, rd); check("R9 R10 status bit 24 only", rd, 32'h0100_0000);

    // R7: clear write lands on the edge-detect cycle
    busWr(2'd1, 32'hFFFF_FFFF);
    busWr(2'd2, 32'hFFFF_FFFF);
    pins = '0; waitCycles(5);
    busWr(2'd2, 32'hFFFF_FFFF);
    busWr(2'd0, 32'h0000_0003);
    @(negedge clk); pins = 32'h0000_0001;       // before edge k
    @(negedge clk);                               // after k
    pins = 32'h0000_0003;                         // bit 1 edge: before edge k+1
    @(negedge clk);                               // after k+1: bit0 edge detected now
    busSel = 1'b1; busWrite = 1'b1; busAddr = 2'd2; busWdata = 32'h0000_0003;
    @(negedge clk);                               // edge k+2: clear and bit0 edge collide
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
    busRd(2'd3, rd); check("R7 edge wins over clear", rd & 32'h1, 32'h1);
    waitCycles(3);
    busWr(2'd2, 32'h0000_0001);
    busRd(2'd3, rd); check("R7 later clear works", rd, 32'h0000_0002);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule